// File: doc/BRIEF.md
# Synchronous DRAM Burst Read Engine

This block is a clocked model of the read path of a synchronous DRAM. A single-cycle read command carries a row and a column address. The engine captures both on the clock edge that accepts the command and waits a fixed access latency. It then sends a burst of words from consecutive columns of the selected row, one word per clock, through a registered data output with a valid flag.

An internal column counter is loaded with the requested column and advances once for every word sent. It wraps inside the column field and never carries into the row. A small computed array stands in for the storage cells, so every word has a known value. While a burst is in progress the engine raises a busy flag and ignores further commands. Once the burst ends it accepts the next command, so reads can follow each other with no gap.

Top module: `sdram_burst_rd`

## Requirements
- R1: While rst_ni is low, and after it is released with no command, valid_o is 0, busy_o is 0 and data_o is all zeros.
- R2: When cmd_i is high on an edge where busy_o is low, the command is accepted. busy_o is then high for the next 11 cycles and low in the 12th.
- R3: The first word of a burst is on data_o with valid_o high right after the 4th rising edge that follows the accepting edge.
- R4: valid_o is high for exactly 8 consecutive cycles per accepted command and is low whenever no burst data is being presented.
- R5: The word sent in position i (i = 0..7) of a burst is the stored word at {row, (col + i) mod 16}. The stored word at 8-bit address a = {row[3:0], col[3:0]} is (a * 32'h9E3779B1) XOR 32'hC0DE0000, truncated to 32 bits.
- R6: The column counter wraps modulo 16 within the column field, and the row of the burst does not change when it wraps.
- R7: A cmd_i pulse on an edge where busy_o is high is ignored. It adds no words, shifts no timing and changes no address.
- R8: A command presented in the cycle when busy_o first returns low is accepted exactly 12 edges after the previous accepting edge, which gives back-to-back bursts.
- R9: row_i and col_i are sampled only on the accepting edge. Changing them during a burst does not alter the words sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Read command, sampled on the clock |
| row_i | input | ROW_W (4) | Row address of the read |
| col_i | input | COL_W (4) | Starting column of the read |
| data_o | output | DATA_W (32) | Registered burst data word |
| valid_o | output | 1 | High while data_o holds a burst word |
| busy_o | output | 1 | High while a burst is in flight and no command can be taken |

## Verification
The embedded properties check, on every cycle, these behaviours:
- the phase counter stays in range;
- a command that arrives while busy never restarts the sequence;
- the column counter steps by one, with wrap, for each word while the row holds;
- valid only rises while busy is high, and stays low once the engine has been idle for two cycles.

Only the bench scenarios can show the following:
- the exact latency to the first word;
- the values and order of the words, including across the column wrap;
- the 12-edge spacing of back-to-back reads;
- that changing the address inputs, or pulsing a command, mid-burst leaves the data unchanged.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  localparam logic [31:0] FILL_MUL = 32'h9E3779B1;
  localparam logic [31:0] FILL_XOR = 32'hC0DE0000;

  // Deterministic content of the stand-in storage array
  function automatic logic [31:0] fill_word(input logic [31:0] addr);
    logic [31:0] prod;
    prod = addr * FILL_MUL;
    return prod ^ FILL_XOR;
  endfunction

endpackage

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int LATENCY   = 4,
  parameter int BURST_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  output logic busy_o,
  output logic accept_o,
  output logic issue_o
);

  localparam int TOTAL = LATENCY + BURST_LEN;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o   = (cnt_q != '0);
  assign accept_o = cmd_i && !busy_o;
  // cnt_q == k means k edges have passed since the accepting edge
  assign issue_o  = (cnt_q >= FIRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (accept_o) begin
      cnt_q <= ONE;
    end else if (busy_o) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + ONE;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_i) |=> (cnt_q != ONE));

endmodule

// File: rtl/sdram_burst_addr.sv
module sdram_burst_addr #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= row_i;
      col_q <= col_i;
    end else if (adv_i) begin
      col_q <= col_q + COL_W'(1); // wraps inside the column field
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (col_q == COL_W'($past(col_q) + COL_W'(1))));

  p_row_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> $stable(row_q));

endmodule

// File: rtl/sdram_cell_array.sv
module sdram_cell_array #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam logic [31:0] WORD = sdram_burst_pkg::fill_word(32'(a));
    assign cells[a] = WORD[DATA_W-1:0];
  end

  assign data_o = cells[{row_i, col_i}];

  initial begin
    a_width_ok: assert (DATA_W <= 32 && DATA_W > 0);
  end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 32,
  parameter int LATENCY   = 4,
  parameter int BURST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);

  logic              accept, issue, busy;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cell_word;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  sdram_burst_seq #(
    .LATENCY  (LATENCY),
    .BURST_LEN(BURST_LEN)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_i),
    .busy_o  (busy),
    .accept_o(accept),
    .issue_o (issue)
  );

  sdram_burst_addr #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .adv_i (issue),
    .row_i (row_i),
    .col_i (col_i),
    .row_o (cur_row),
    .col_o (cur_col)
  );

  sdram_cell_array #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) u_cells (
    .row_i (cur_row),
    .col_i (cur_col),
    .data_o(cell_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= issue;
      if (issue) data_q <= cell_word;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign busy_o  = busy;

  p_valid_in_burst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> busy_o);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !valid_o);

endmodule

// File: tb/sdram_burst_rd_tb_top.sv
module sdram_burst_rd_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_i = 1'b0;
  logic [3:0]  row_i = '0;
  logic [3:0]  col_i = '0;
  logic [31:0] data_o;
  logic        valid_o;
  logic        busy_o;

  sdram_burst_rd dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .row_i  (row_i),
    .col_i  (col_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .busy_o (busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    int          at;
    logic [31:0] w;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  function automatic logic [31:0] model_word(input logic [3:0] r, input logic [3:0] c);
    logic [31:0] a;
    a = {24'd0, r, c};
    return (a * 32'h9E3779B1) ^ 32'hC0DE0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "valid with no pending word", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          check(cyc == e.at, "R3", "word timing", 32'(cyc), 32'(e.at));
          check(data_o == e.w, "R5", "word value", data_o, e.w);
        end
      end else if (q.size() > 0 && q[0].at <= cyc) begin
        check(1'b0, "R4", "valid missing", 32'(cyc), 32'(q[0].at));
        e = q.pop_front();
      end
    end
  end

  // Driver: issue one read once idle, push 8 expected words
  task automatic rd(input logic [3:0] r, input logic [3:0] c, output int acc);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    row_i = r;
    col_i = c;
    cmd_i = 1'b1;
    acc = cyc + 1;
    for (int i = 0; i < 8; i++) begin
      exp_t it;
      it.at = acc + 4 + i;
      it.w  = model_word(r, 4'(c + 4'(i)));
      q.push_back(it);
    end
    @(negedge clk);
    cmd_i = 1'b0;
    row_i = ~r;
    col_i = ~c;
    check(busy_o == 1'b1, "R2", "busy after accept", 32'(busy_o), 32'd1);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int a1, a2;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1", "valid in reset", 32'(valid_o), 32'd0);
    check(busy_o == 1'b0, "R1", "busy in reset", 32'(busy_o), 32'd0);
    check(data_o == '0, "R1", "data in reset", data_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(valid_o == 1'b0 && busy_o == 1'b0, "R1", "idle after reset",
          {30'd0, valid_o, busy_o}, 32'd0);

    // R2/R3/R4/R5: plain burst and busy length
    rd(4'd3, 4'd2, a1);
    repeat (10) @(negedge clk);
    check(busy_o == 1'b1, "R2", "busy at cycle 11", 32'(busy_o), 32'd1);
    @(negedge clk);
    check(busy_o == 1'b0, "R2", "busy low at cycle 12", 32'(busy_o), 32'd0);
    drain();

    // R6: column wrap inside the row
    rd(4'd5, 4'd14, a1);
    drain();

    // R7: command while busy is ignored
    rd(4'd9, 4'd0, a1);
    repeat (3) @(negedge clk);
    cmd_i = 1'b1;
    row_i = 4'd1;
    col_i = 4'd7;
    repeat (4) @(negedge clk);
    cmd_i = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && busy_o == 1'b0, "R7", "no extra burst",
          {30'd0, valid_o, busy_o}, 32'd0);

    // R9: address inputs change mid-burst
    rd(4'd12, 4'd6, a1);
    for (int i = 0; i < 6; i++) begin
      row_i = 4'(i + 1);
      col_i = 4'(15 - i);
      @(negedge clk);
    end
    drain();

    // R8: back-to-back bursts
    rd(4'd2, 4'd9, a1);
    rd(4'd7, 4'd3, a2);
    check(a2 - a1 == 12, "R8", "accept spacing", 32'(a2 - a1), 32'd12);
    drain();
    check(q.size() == 0, "R4", "scoreboard empty", 32'(q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule